// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block holds a bank of independent down-counters behind a small synchronous register port. Each channel has a reload register, a live counter, a running count of underflows, a sticky interrupt status bit with a write-one-to-clear register, and a mask bit. One global run bit gates every channel. Each channel also has its own local enable. When a channel passes zero it reloads and raises its status. Each channel's masked interrupt appears on a dedicated output line.

Software reads a channel's live count coherently in two steps. A read of the underflow-count register also copies the live counter into a per-channel snapshot. A following read of the current-value register returns that snapshot, so it must come second. A free-running rising time base is obtained by loading an all-ones reload value and inverting the snapshot.

Top module: `dct_timer_bank`

## Requirements
- R1: The register at byte address 0x00 holds the global run bit in bit 0, readable and writable. The register at 0x10 always reads the parameter REV, and writes to it are ignored.
- R2: Channel n (0..NCH-1) owns a 32-byte page starting at 0x20 + 0x20*n. Its registers sit at these byte offsets: 0x00 local enable (bit 0), 0x04 reload, 0x08 current value (snapshot), 0x0C underflow count, 0x10 status (bit 0), 0x14 clear, 0x18 mask (bit 0). Writable fields read back what was written.
- R3: A channel counter decrements by one per clock while the global run bit is 1, its local enable is 1, and it was also 1 on the previous clock. Otherwise it holds, except as stated in R4.
- R4: On the clock after the local enable changes from 0 to 1, the counter loads the reload value, whatever the global run bit is.
- R5: When a running counter is 0, the next clock reloads it from the reload register, adds one to the underflow count, and sets the status bit.
- R6: A read of the underflow-count register returns the count and copies the live counter into the snapshot on the same clock. Reads of the current-value register return the snapshot.
- R7: Writing 1 in bit 0 of the clear register clears the status bit. If an underflow happens on the same clock, the status stays set.
- R8: Interrupt line n equals channel n's status AND mask, and it changes on the same clock edge as they do.
- R9: Reads of any unmapped offset, of the clear register, or of pages beyond the last channel return 0. Writes to the revision, current-value, underflow-count and status registers have no effect.
- R10: Read data is registered and appears on rdata_o the clock after rd_en_i. It is 0 on clocks that follow no read. Synchronous reset clears every register, and so rdata_o and irq_o, to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW (8) | Byte address |
| wdata_i | input | CW (32) | Write data |
| rdata_o | output | CW (32) | Registered read data |
| irq_o | output | NCH (4) | Masked interrupt per channel |

## Verification
The hardest case to reach from the ports is an underflow that falls on the same clock as a clear write, because the counter must be at zero exactly when the clear lands. The bench forces this by loading a reload value of zero into a running channel. That channel then underflows on every clock, so every clear write collides with a set. Random register traffic with small reload values drives many natural underflows, snapshot reads and enable toggles. A cycle-level reference model then predicts every read and every interrupt line.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // Channel page offsets (byte address bits [4:0])
  localparam logic [4:0] OFF_CFG  = 5'h00;
  localparam logic [4:0] OFF_RLD  = 5'h04;
  localparam logic [4:0] OFF_CUR  = 5'h08;
  localparam logic [4:0] OFF_OVF  = 5'h0C;
  localparam logic [4:0] OFF_STS  = 5'h10;
  localparam logic [4:0] OFF_CLR  = 5'h14;
  localparam logic [4:0] OFF_MSK  = 5'h18;
  // Global page offsets
  localparam logic [4:0] OFF_GCTL = 5'h00;
  localparam logic [4:0] OFF_REV  = 5'h10;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [4:0] off;
  } slot_req_t;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  output slot_req_t             glb_o,
  output slot_req_t [NCH-1:0]   ch_o
);
  localparam int PW = AW - 5;

  logic [PW-1:0] page;
  assign page = addr_i[AW-1:5];

  always_comb begin
    glb_o.wr  = wr_en_i && (page == '0);
    glb_o.rd  = rd_en_i && (page == '0);
    glb_o.off = addr_i[4:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    logic hit;
    assign hit       = (page == PW'(i + 1));
    assign ch_o[i].wr  = wr_en_i && hit;
    assign ch_o[i].rd  = rd_en_i && hit;
    assign ch_o[i].off = addr_i[4:0];
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_i,
  input  slot_req_t     req_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          irq_o
);
  logic          len_q, prev_q, sts_q, msk_q, irq_q;
  logic [CW-1:0] rld_q, cnt_q, ovf_q, shd_q;
  logic          arm, run, uf, snap, sts_d, msk_d;

  always_comb begin
    arm   = len_q & ~prev_q;
    run   = gen_i & len_q & prev_q;
    uf    = run && (cnt_q == '0);
    snap  = req_i.rd && (req_i.off == OFF_OVF);
    msk_d = (req_i.wr && req_i.off == OFF_MSK) ? wdata_i[0] : msk_q;
    if (uf)
      sts_d = 1'b1;
    else if (req_i.wr && req_i.off == OFF_CLR && wdata_i[0])
      sts_d = 1'b0;
    else
      sts_d = sts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= 1'b0;
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
      msk_q  <= 1'b0;
      irq_q  <= 1'b0;
      rld_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= '0;
      shd_q  <= '0;
    end else begin
      prev_q <= len_q;
      if (req_i.wr && req_i.off == OFF_CFG) len_q <= wdata_i[0];
      if (req_i.wr && req_i.off == OFF_RLD) rld_q <= wdata_i;
      if (arm) begin
        cnt_q <= rld_q;
      end else if (uf) begin
        cnt_q <= rld_q;
        ovf_q <= ovf_q + 1'b1;
      end else if (run) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (snap) shd_q <= cnt_q;
      sts_q <= sts_d;
      msk_q <= msk_d;
      irq_q <= sts_d & msk_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i.rd) begin
      case (req_i.off)
        OFF_CFG: rdata_o = CW'(len_q);
        OFF_RLD: rdata_o = rld_q;
        OFF_CUR: rdata_o = shd_q;
        OFF_OVF: rdata_o = ovf_q;
        OFF_STS: rdata_o = CW'(sts_q);
        OFF_MSK: rdata_o = CW'(msk_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_q;

  // R3: a stopped channel holds its count
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!len_q || (!gen_i && prev_q)) |=> $stable(cnt_q));
  // R3: a running non-zero channel steps down by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (gen_i && len_q && prev_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4: rising local enable loads reload value
  p_arm_r4: assert property (@(posedge clk) disable iff (rst)
    (len_q && !prev_q) |=> (cnt_q == $past(rld_q)));
  // R5: underflow reloads, counts, and flags
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (gen_i && len_q && prev_q && cnt_q == '0) |=>
      (sts_q && cnt_q == $past(rld_q) && ovf_q == $past(ovf_q) + 1'b1));
  // R6: snapshot captures the live count
  p_snap_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i.rd && req_i.off == OFF_OVF) |=> (shd_q == $past(cnt_q)));
  // R8: interrupt follows status and mask
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (sts_q & msk_q));
endmodule

// File: rtl/dct_timer_bank.sv
module dct_timer_bank
  import dct_pkg::*;
#(
  parameter int          NCH = 4,
  parameter int          CW  = 32,
  parameter int          AW  = 8,
  parameter logic [31:0] REV = 32'h0001_0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  slot_req_t               glb_req;
  slot_req_t [NCH-1:0]     ch_req;
  logic [NCH-1:0][CW-1:0]  ch_rd;
  logic [CW-1:0]           rd_d, rdata_q;
  logic                    gen_q;

  dct_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .glb_o   (glb_req),
    .ch_o    (ch_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dct_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .gen_i   (gen_q),
      .req_i   (ch_req[i]),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[i]),
      .irq_o   (irq_o[i])
    );
  end

  always_comb begin
    rd_d = '0;
    if (glb_req.rd) begin
      if (glb_req.off == OFF_GCTL)     rd_d = CW'(gen_q);
      else if (glb_req.off == OFF_REV) rd_d = CW'(REV);
    end
    for (int i = 0; i < NCH; i++) rd_d = rd_d | ch_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (glb_req.wr && glb_req.off == OFF_GCTL) gen_q <= wdata_i[0];
      rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;

  // R10: no read strobe, zero read data
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rdata_o == '0));
  // R1: revision register content
  p_rev_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == AW'(8'h10)) |=> (rdata_o == CW'(REV)));
  // R1: global run bit only changes by a write to address 0
  p_gen_r1: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && addr_i == '0) |=> $stable(gen_q));
endmodule

// File: tb/dct_timer_bank_test.sv
module dct_timer_bank_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCH = 4;
  localparam logic [31:0] REV = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct_timer_bank #(.NCH(NCH), .REV(REV)) uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Reference model built from the requirements
  logic        m_gen;
  logic [31:0] m_rdata;
  logic        m_len[NCH], m_prev[NCH], m_sts[NCH], m_msk[NCH], m_irq[NCH];
  logic [31:0] m_rld[NCH], m_cnt[NCH], m_ovf[NCH], m_shd[NCH];

  function automatic logic [31:0] mread(input logic [7:0] a);
    int         p = int'(a[7:5]);
    logic [4:0] o = a[4:0];
    if (p == 0) return (o == 5'h00) ? {31'b0, m_gen} : (o == 5'h10 ? REV : 32'h0);
    if (p > NCH) return 32'h0;
    case (o)
      5'h00:   return {31'b0, m_len[p-1]};
      5'h04:   return m_rld[p-1];
      5'h08:   return m_shd[p-1];
      5'h0C:   return m_ovf[p-1];
      5'h10:   return {31'b0, m_sts[p-1]};
      5'h18:   return {31'b0, m_msk[p-1]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gen <= 1'b0; m_rdata <= '0;
      for (int c = 0; c < NCH; c++) begin
        m_len[c] <= 0; m_prev[c] <= 0; m_sts[c] <= 0; m_msk[c] <= 0; m_irq[c] <= 0;
        m_rld[c] <= 0; m_cnt[c] <= 0; m_ovf[c] <= 0; m_shd[c] <= 0;
      end
    end else begin
      m_rdata <= rd_en ? mread(addr) : 32'h0;
      if (wr_en && addr == 8'h00) m_gen <= wdata[0];
      for (int c = 0; c < NCH; c++) begin
        logic sel, uf, ns, nm;
        logic [4:0] o;
        sel = (int'(addr[7:5]) == c + 1);
        o   = addr[4:0];
        uf  = 1'b0;
        if (wr_en && sel && o == 5'h00) m_len[c] <= wdata[0];
        if (wr_en && sel && o == 5'h04) m_rld[c] <= wdata;
        if (rd_en && sel && o == 5'h0C) m_shd[c] <= m_cnt[c];
        m_prev[c] <= m_len[c];
        if (m_len[c] && !m_prev[c]) m_cnt[c] <= m_rld[c];
        else if (m_gen && m_len[c] && m_prev[c]) begin
          if (m_cnt[c] == 0) begin
            m_cnt[c] <= m_rld[c]; m_ovf[c] <= m_ovf[c] + 1; uf = 1'b1;
          end else m_cnt[c] <= m_cnt[c] - 1;
        end
        nm = (wr_en && sel && o == 5'h18) ? wdata[0] : m_msk[c];
        ns = uf ? 1'b1 : ((wr_en && sel && o == 5'h14 && wdata[0]) ? 1'b0 : m_sts[c]);
        m_sts[c] <= ns; m_msk[c] <= nm; m_irq[c] <= ns & nm;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 rdata vs model", rdata, m_rdata);
      for (int c = 0; c < NCH; c++)
        chk("R8 irq vs model", {31'b0, irq[c]}, {31'b0, m_irq[c]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] chaddr(input int c, input logic [4:0] o);
    return 8'(32 + 32 * c) + {3'b0, o};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    chk("R10 irq after reset", {28'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R10 global reg after reset", v, 32'h0);
    rd(chaddr(2, 5'h0C), v); chk("R10 ovf after reset", v, 32'h0);

    // R1 / R9: revision
    rd(8'h10, v); chk("R1 revision", v, REV);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R9 revision write ignored", v, REV);

    // R2: per-channel register placement
    for (int c = 0; c < NCH; c++) wr(chaddr(c, 5'h04), 32'hA0 + 32'(c));
    for (int c = 0; c < NCH; c++) begin
      rd(chaddr(c, 5'h04), v); chk("R2 reload readback", v, 32'hA0 + 32'(c));
    end
    wr(chaddr(3, 5'h18), 32'h1);
    rd(chaddr(3, 5'h18), v); chk("R2 mask readback", v, 32'h1);
    wr(chaddr(3, 5'h18), 32'h0);

    // R4 with global stopped: enable arms the counter
    wr(chaddr(0, 5'h00), 32'h1);
    repeat (3) @(negedge clk);
    rd(chaddr(0, 5'h0C), v); chk("R6 ovf count zero", v, 32'h0);
    rd(chaddr(0, 5'h08), v); chk("R4 counter loaded from reload", v, 32'hA0);

    // R3: six enabled edges
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(chaddr(0, 5'h0C), v);
    rd(chaddr(0, 5'h08), v); chk("R3 decrement count", v, 32'hA0 - 32'd6);
    repeat (4) @(negedge clk);
    rd(chaddr(0, 5'h0C), v);
    rd(chaddr(0, 5'h08), v); chk("R3 hold when global off", v, 32'hA0 - 32'd6);

    // R9: writes to read-only channel registers
    wr(chaddr(0, 5'h08), 32'h1234);
    wr(chaddr(0, 5'h0C), 32'h55);
    rd(chaddr(0, 5'h0C), v); chk("R9 ovf write ignored", v, 32'h0);
    rd(chaddr(0, 5'h08), v); chk("R9 cur write ignored", v, 32'hA0 - 32'd6);
    rd(8'hE0, v); chk("R9 page beyond channels", v, 32'h0);
    rd(chaddr(1, 5'h1C), v); chk("R9 unmapped offset", v, 32'h0);
    rd(chaddr(1, 5'h14), v); chk("R9 clear reads zero", v, 32'h0);

    // R5 / R7: reload zero underflows every clock
    wr(chaddr(1, 5'h04), 32'h0);
    wr(chaddr(1, 5'h18), 32'h1);
    wr(chaddr(1, 5'h00), 32'h1);
    wr(8'h00, 32'h1);
    repeat (3) @(negedge clk);
    wr(chaddr(1, 5'h14), 32'h1);
    rd(chaddr(1, 5'h10), v); chk("R7 set wins over clear", v, 32'h1);
    chk("R8 irq raised", {31'b0, irq[1]}, 32'h1);
    wr(8'h00, 32'h0);
    rd(chaddr(1, 5'h0C), v); chk("R5 underflow count", v, m_ovf[1]);
    chk("R5 underflows occurred", {31'b0, (v > 32'd3)}, 32'h1);
    wr(chaddr(1, 5'h14), 32'h1);
    rd(chaddr(1, 5'h10), v); chk("R7 status cleared", v, 32'h0);
    chk("R8 irq dropped", {31'b0, irq[1]}, 32'h0);

    // Random traffic
    wr(8'h00, 32'h1);
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 10);
      int c  = int'($urandom % NCH);
      case (op)
        0: wr(chaddr(c, 5'h04), $urandom % 24);
        1: wr(chaddr(c, 5'h00), $urandom % 2);
        2: wr(chaddr(c, 5'h18), $urandom % 2);
        3: wr(chaddr(c, 5'h14), $urandom % 2);
        4: wr(8'h00, ($urandom % 5) != 0);
        5: begin rd(chaddr(c, 5'h0C), v); rd(chaddr(c, 5'h08), v); end
        6: rd(8'($urandom), v);
        7: wr(8'($urandom), $urandom);
        default: @(negedge clk);
      endcase
    end
    rd(chaddr(0, 5'h0C), v); chk("R6 final ovf ch0", v, m_ovf[0]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule